// File: doc/BRIEF.md
# Start-Bit Framed Serial Segment Latch

This block takes a two-wire serial stream (a serial clock and a data line) and drives a bank of static, non-multiplexed segment outputs. There is no separate load strobe. Each frame opens with a start bit of logic one, followed by the payload bits. The block shifts every bit into a chain one stage longer than the payload. When the start bit reaches the last stage, the block copies the payload into the output latches while the serial clock is still high. On the next falling edge of the serial clock it wipes the chain, which leaves it ready for the next frame.

The serial inputs are slow, at most 0.5 MHz. Each one passes through a two-flop synchroniser into the fast system clock. Only the input sampling stage survives the wipe, so frames can follow each other with no gap. A build parameter selects one of two variants. In the first, all payload bits drive outputs. In the second, the last output is given up and a data-enable input is used instead: rising serial-clock edges that arrive while enable is low are ignored. A one-cycle `frame_done` pulse marks every load.

Top module: `seg_frame_latch`

## Requirements
- R1: A frame is a logic-one start bit followed by exactly SEGS (default 35) payload bits. The load happens on the (SEGS+1)-th accepted rising edge of `ser_clk`, and `frame_done` is high for exactly one system cycle when it does.
- R2: The first payload bit after the start bit lands on `seg_out[0]`, and the k-th payload bit lands on `seg_out[k-1]`. A payload value of 1 drives its output to 1 (on).
- R3: `seg_out` and `frame_done` change on the 4th system clock rising edge after the final `ser_clk` rise appears at the pin. That is two synchroniser stages, one shift and one load, so the load falls inside the serial clock's high phase.
- R4: On the `ser_clk` falling edge that follows a completed frame, the shift chain is cleared. A start bit that arrives on the very next rising edge is captured, so frames may be sent back to back.
- R5: If fewer than SEGS+1 rising edges arrive, nothing is loaded and the chain keeps its contents. Supplying the missing edges later completes that same frame.
- R6: A synchronous active-high `rst` clears every synchroniser, shift stage and output latch and holds `frame_done` low. The next start bit and its clocks then work normally.
- R7: Between loads `seg_out` holds still. An output bit updates only when its newly loaded value differs from its current value, so a repeated identical frame leaves `seg_out` unchanged.
- R8: With ENABLE_MODE=1, `seg_out[SEGS-1]` is always 0 and `ser_clk` rising edges are ignored while the synchronised `data_en` is low. With ENABLE_MODE=0, `data_en` has no effect.
- R9: Zero bits that arrive before a start bit never cause a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `ser_clk` |
| rst | input | 1 | Synchronous active-high power-on reset |
| ser_clk | input | 1 | Serial clock, asynchronous to `clk` |
| ser_data | input | 1 | Serial data, sampled on `ser_clk` rising edges |
| data_en | input | 1 | Serial enable, used only when ENABLE_MODE=1 |
| seg_out | output | SEGS | Latched segment outputs, 1 = on |
| frame_done | output | 1 | One-cycle pulse marking a load |

## Verification
A load becomes visible on the fourth system clock edge after the last serial rise reaches the pins. The bench records the cycle count when it raises `ser_clk`, and the monitor checks that `frame_done` shows up exactly four cycles later. Each result is sampled on the falling edge of `clk`, after the register that produces it has updated. Every serial bit is held for 8 system cycles on each side of its rise, which keeps the load inside the high phase and the clear inside the low phase. The "no load" cases are checked after waiting more than the four-cycle latency: an unexpected `frame_done` with an empty expectation queue is counted as a failure.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

    parameter int unsigned DEF_SEGS    = 35;
    parameter int unsigned SYNC_STAGES = 2;

    // Synchronised serial inputs plus edge events of the serial clock.
    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
        logic dat;
        logic en;
    } ser_evt_t;

    function automatic int unsigned chain_len(input int unsigned segs);
        return segs + 1;
    endfunction

    function automatic int unsigned driven_segs(input int unsigned segs, input bit en_mode);
        return en_mode ? segs - 1 : segs;
    endfunction

endpackage

// File: rtl/sfl_input_sync.sv
module sfl_input_sync
    import sfl_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_STAGES
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     ser_clk,
    input  logic     ser_data,
    input  logic     data_en,
    output ser_evt_t evt
);
    localparam int unsigned W = 3;

    logic [W-1:0] stg [STAGES];
    logic [W-1:0] synced;
    logic         clk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(STAGES); i++) stg[i] <= '0;
            clk_prev <= 1'b0;
        end else begin
            stg[0] <= {data_en, ser_data, ser_clk};
            for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
            clk_prev <= synced[0];
        end
    end

    assign synced   = stg[STAGES-1];
    assign evt.lvl  = synced[0];
    assign evt.dat  = synced[1];
    assign evt.en   = synced[2];
    assign evt.rise = synced[0] & ~clk_prev;
    assign evt.fall = ~synced[0] & clk_prev;

endmodule

// File: rtl/sfl_shift_chain.sv
module sfl_shift_chain #(
    parameter int unsigned LEN = 36
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           shift,
    input  logic           din,
    input  logic           wipe,
    output logic [LEN-1:0] chain,
    output logic           full
);
    // Stage 0 holds the newest bit; the start marker arrives at LEN-1.
    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else if (shift) begin
            chain <= {chain[LEN-2:0], din};
        end else if (wipe && chain[LEN-1]) begin
            chain <= '0;
        end
    end

    assign full = chain[LEN-1];

endmodule

// File: rtl/sfl_seg_latch.sv
module sfl_seg_latch #(
    parameter int unsigned SEGS   = 35,
    parameter int unsigned DRIVEN = 35
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [SEGS-1:0] payload,
    output logic [SEGS-1:0] seg
);
    for (genvar i = 0; i < int'(SEGS); i++) begin : g_bit
        if (i < int'(DRIVEN)) begin : g_drv
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    bit_q <= 1'b0;
                end else if (load && (payload[i] != bit_q)) begin
                    bit_q <= payload[i];
                end
            end
            assign seg[i] = bit_q;
        end else begin : g_off
            assign seg[i] = 1'b0;
        end
    end

endmodule

// File: rtl/seg_frame_latch.sv
module seg_frame_latch
    import sfl_pkg::*;
#(
    parameter int unsigned SEGS        = DEF_SEGS,
    parameter bit          ENABLE_MODE = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ser_clk,
    input  logic            ser_data,
    input  logic            data_en,
    output logic [SEGS-1:0] seg_out,
    output logic            frame_done
);
    localparam int unsigned LEN    = chain_len(SEGS);
    localparam int unsigned DRIVEN = driven_segs(SEGS, ENABLE_MODE);

    ser_evt_t       evt;
    logic           sc_rise;
    logic           sc_fall;
    logic           en_s;
    logic           shift_en;
    logic           shift_d;
    logic           chain_full;
    logic           load;
    logic [LEN-1:0] chain_q;
    logic [SEGS-1:0] payload;

    sfl_input_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .data_en  (data_en),
        .evt      (evt)
    );

    assign sc_rise = evt.rise;
    assign sc_fall = evt.fall;
    assign en_s    = evt.en;

    if (ENABLE_MODE) begin : g_gate
        assign shift_en = sc_rise & en_s;
    end else begin : g_free
        assign shift_en = sc_rise;
    end

    sfl_shift_chain #(.LEN(LEN)) u_chain (
        .clk   (clk),
        .rst   (rst),
        .shift (shift_en),
        .din   (evt.dat),
        .wipe  (sc_fall),
        .chain (chain_q),
        .full  (chain_full)
    );

    // Payload bit 1 sits just below the start marker.
    for (genvar k = 0; k < int'(SEGS); k++) begin : g_map
        assign payload[k] = chain_q[SEGS-1-k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_d    <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            shift_d    <= shift_en;
            frame_done <= load;
        end
    end

    // Load once, just after the shift that brought the start marker to the top,
    // qualified by the serial clock still being high.
    assign load = shift_d & chain_full & evt.lvl;

    sfl_seg_latch #(.SEGS(SEGS), .DRIVEN(DRIVEN)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .payload (payload),
        .seg     (seg_out)
    );

endmodule

// File: rtl/sfl_checker.sv
module sfl_checker #(
    parameter int unsigned SEGS        = 35,
    parameter bit          ENABLE_MODE = 1'b0
) (
    input logic            clk,
    input logic            rst,
    input logic [SEGS-1:0] seg_out,
    input logic            frame_done,
    input logic [SEGS:0]   chain,
    input logic            sc_rise,
    input logic            sc_fall,
    input logic            en_s
);
    // R6
    a_r6_reset_clears: assert property (@(posedge clk)
        rst |=> (seg_out == '0 && !frame_done && chain == '0));

    // R7
    a_r7_hold_between_loads: assert property (@(posedge clk) disable iff (rst)
        !frame_done |-> $stable(seg_out));

    // R1
    a_r1_done_single_cycle: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    // R4
    a_r4_wipe_after_frame: assert property (@(posedge clk) disable iff (rst)
        (sc_fall && chain[SEGS]) |=> (chain == '0));

    // R5
    a_r5_no_load_without_marker: assert property (@(posedge clk) disable iff (rst)
        !chain[SEGS] |=> !frame_done);

    // R8
    a_r8_disabled_edge_ignored: assert property (@(posedge clk) disable iff (rst)
        (ENABLE_MODE && sc_rise && !en_s) |=> $stable(chain));

endmodule

bind seg_frame_latch sfl_checker #(.SEGS(SEGS), .ENABLE_MODE(ENABLE_MODE)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .seg_out    (seg_out),
    .frame_done (frame_done),
    .chain      (chain_q),
    .sc_rise    (sc_rise),
    .sc_fall    (sc_fall),
    .en_s       (en_s)
);

// File: tb/test_seg_frame_latch.sv
module test_seg_frame_latch;
    localparam int SEGS = 35;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic sclk_a = 1'b0, sclk_b = 1'b0, sdat = 1'b0, en_a = 1'b0, en_b = 1'b1;
    logic [SEGS-1:0] seg_a, seg_b;
    logic done_a, done_b;

    seg_frame_latch #(.SEGS(SEGS), .ENABLE_MODE(1'b0)) i_seg_frame_latch (
        .clk(clk), .rst(rst), .ser_clk(sclk_a), .ser_data(sdat), .data_en(en_a),
        .seg_out(seg_a), .frame_done(done_a));

    seg_frame_latch #(.SEGS(SEGS), .ENABLE_MODE(1'b1)) i_seg_frame_latch_de (
        .clk(clk), .rst(rst), .ser_clk(sclk_b), .ser_data(sdat), .data_en(en_b),
        .seg_out(seg_b), .frame_done(done_b));

    int n_chk = 0, n_fail = 0;
    longint cyc = 0, rise_cyc = 0;
    bit finished = 0;
    logic [SEGS-1:0] q_a[$], q_b[$];
    logic [SEGS-1:0] mask_b;

    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input bit to_b, input logic en);
        @(negedge clk);
        sdat = b;
        en_b = en;
        repeat (4) @(negedge clk);
        if (to_b) sclk_b = 1'b1; else sclk_a = 1'b1;
        rise_cyc = cyc;
        repeat (8) @(negedge clk);
        sclk_a = 1'b0;
        sclk_b = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_frame(input logic [SEGS-1:0] p, input bit to_b);
        if (to_b) q_b.push_back(p & mask_b); else q_a.push_back(p);
        send_bit(1'b1, to_b, 1'b1);
        for (int i = 0; i < SEGS; i++) send_bit(p[i], to_b, 1'b1);
        repeat (6) @(negedge clk);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (done_a) begin
                if (q_a.size() == 0) begin
                    check(1'b0, "R5/R9 unexpected load", 64'(seg_a), 64'(0));
                end else begin
                    logic [SEGS-1:0] e;
                    e = q_a.pop_front();
                    check(seg_a == e, "R1/R2 payload", 64'(seg_a), 64'(e));
                    check(cyc - rise_cyc == 4, "R3 latency", 64'(cyc - rise_cyc), 64'(4));
                end
            end
            if (done_b) begin
                if (q_b.size() == 0) begin
                    check(1'b0, "R8 unexpected load", 64'(seg_b), 64'(0));
                end else begin
                    logic [SEGS-1:0] e;
                    e = q_b.pop_front();
                    check(seg_b == e, "R8 payload", 64'(seg_b), 64'(e));
                    check(seg_b[SEGS-1] == 1'b0, "R8 top output off", 64'(seg_b[SEGS-1]), 64'(0));
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [SEGS-1:0] p, snap;
        mask_b = {1'b0, {(SEGS-1){1'b1}}};
        repeat (5) @(negedge clk);
        // R6: reset state
        check(seg_a == '0 && !done_a, "R6 reset outputs", 64'(seg_a), 64'(0));
        check(seg_b == '0 && !done_b, "R6 reset outputs de", 64'(seg_b), 64'(0));
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1, R2: directed payloads
        send_frame(35'h1, 0);
        check(seg_a == 35'h1, "R2 first bit to seg 0", 64'(seg_a), 64'(35'h1));
        send_frame(35'h4_0000_0000, 0);
        check(seg_a == 35'h4_0000_0000, "R2 last bit to top seg", 64'(seg_a), 64'(35'h4_0000_0000));
        send_frame({SEGS{1'b1}}, 0);
        send_frame(35'h2_AAAA_AAAA, 0);
        // R4: back-to-back frames, no gap
        q_a.push_back(35'h5_1234_5678);
        send_bit(1'b1, 0, 1'b1);
        for (int i = 0; i < SEGS; i++) send_bit(p_of(35'h5_1234_5678, i), 0, 1'b1);
        q_a.push_back(35'h0_0F0F_00FF);
        send_bit(1'b1, 0, 1'b1);
        for (int i = 0; i < SEGS; i++) send_bit(p_of(35'h0_0F0F_00FF, i), 0, 1'b1);
        repeat (6) @(negedge clk);
        check(seg_a == 35'h0_0F0F_00FF, "R4 back-to-back", 64'(seg_a), 64'(35'h0_0F0F_00FF));

        // R7: repeated identical frame leaves outputs unchanged
        snap = seg_a;
        send_frame(35'h0_0F0F_00FF, 0);
        check(seg_a == snap, "R7 repeat frame", 64'(seg_a), 64'(snap));

        // R9: leading zeros without a start bit
        for (int i = 0; i < 10; i++) send_bit(1'b0, 0, 1'b1);
        repeat (10) @(negedge clk);
        check(seg_a == snap, "R9 idle zeros no load", 64'(seg_a), 64'(snap));
        send_frame(35'h3_C3C3_C3C3, 0);

        // R5: partial frame, then completion
        p = 35'h1_2480_1248;
        snap = seg_a;
        q_a.push_back(p);
        send_bit(1'b1, 0, 1'b1);
        for (int i = 0; i < 19; i++) send_bit(p[i], 0, 1'b1);
        repeat (50) @(negedge clk);
        check(seg_a == snap, "R5 partial no load", 64'(seg_a), 64'(snap));
        check(q_a.size() == 1, "R5 load not consumed", 64'(q_a.size()), 64'(1));
        for (int i = 19; i < SEGS; i++) send_bit(p[i], 0, 1'b1);
        repeat (6) @(negedge clk);
        check(seg_a == p, "R5 completed frame", 64'(seg_a), 64'(p));

        // R6: reset mid-frame, then normal frame
        for (int i = 0; i < 10; i++) send_bit(1'b1, 0, 1'b1);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(seg_a == '0, "R6 reset clears", 64'(seg_a), 64'(0));
        rst = 1'b0;
        repeat (3) @(negedge clk);
        send_frame(35'h0_0000_8001, 0);
        check(seg_a == 35'h0_0000_8001, "R6 frame after reset", 64'(seg_a), 64'(35'h0_0000_8001));

        // R8: enable variant
        send_frame({SEGS{1'b1}}, 1);
        check(seg_b == mask_b, "R8 all ones top off", 64'(seg_b), 64'(mask_b));
        check(seg_a == 35'h0_0000_8001, "R8 other instance untouched", 64'(seg_a), 64'(35'h0_0000_8001));
        p = 35'h2_5A5A_0F0F;
        q_b.push_back(p & mask_b);
        send_bit(1'b1, 1, 1'b1);
        for (int i = 0; i < 10; i++) send_bit(p[i], 1, 1'b1);
        for (int i = 0; i < 3; i++) send_bit(1'b1, 1, 1'b0);
        for (int i = 10; i < SEGS; i++) send_bit(p[i], 1, 1'b1);
        repeat (6) @(negedge clk);
        check(seg_b == (p & mask_b), "R8 disabled edges ignored", 64'(seg_b), 64'(p & mask_b));
        check(q_a.size() == 0 && q_b.size() == 0, "R1 all loads seen", 64'(q_a.size() + q_b.size()), 64'(0));

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    function automatic logic p_of(input logic [SEGS-1:0] v, input int i);
        return v[i];
    endfunction

endmodule